// File: doc/BRIEF.md
# Selectable Output Driver with Held Configuration Bit

This block drives six configuration outputs of a board-management chip. Five of them are a per-bit two-way selection. Each one shows either an external input pin or a bit of a six-bit word held in nonvolatile memory. The sixth output carries the remaining bit of that word through a hold stage. The hold stage is transparent while the stored word is selected. It freezes when selection moves to the external inputs.

After reset, a select pin chooses the source. A two-bit control register, written by the serial bus front end on its acknowledge strobe, can take over that choice. While the register owns the choice, the select pin does nothing. The hold stage then captures at the acknowledge of the write that hands control over.

An active-low force input clamps the outputs to 0, but only while the stored word is the source. While the memory is being reprogrammed, the outputs keep showing the word as it was before programming began.

Top module: `mux_latch_out`

## Requirements
- R1: After reset the control register reads 0 and the select pin owns the choice, so with the pin low the five selectable outputs equal stored bits 4..0.
- R2: In pin mode with the select pin at 0, output bit i (i = 0..4) equals stored-word bit i.
- R3: In pin mode with the select pin at 1, the five selectable outputs equal the five external inputs.
- R4: Whenever the stored word is the source, the held output follows stored bit 5 in the same cycle.
- R5: In pin mode, when the select pin rises, the held output keeps the stored bit 5 seen in the last cycle before the rise. It stays at that value while the pin stays high.
- R6: A control write with bit 1 = 1 gives the choice to bit 0: 1 selects the stored word and 0 selects the external inputs. The new choice takes effect from the cycle after the acknowledge strobe. The select pin is then ignored. A write with bit 1 = 0 returns the choice to the pin.
- R7: In the cycle where the acknowledge strobe carries a write with bit 1 = 1 while bit 1 is currently 0, the held output captures the stored bit 5 of that cycle. It keeps that value while the external inputs are selected.
- R8: With the force input at 0 and the stored word as the source, all five selectable outputs and the held output are 0.
- R9: With the external inputs as the source, the force input has no effect on any output.
- R10: While the busy flag is 1, the outputs use the stored word as it was in the last cycle the flag was 0. When the flag drops, they use the live word again.
- R11: The control readback byte is six zeros above bits 1 and 0 of the register. The word readback byte is two zeros, then stored bit 5, then stored bits 4 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selPin | input | 1 | External source select: 0 selects the stored word, 1 selects the external inputs |
| forceLowN | input | 1 | Active-low clamp of the outputs while the stored word is selected |
| extIn | input | 5 | External inputs for the selectable outputs |
| storedWord | input | 6 | Nonvolatile word: bit 5 feeds the held output, bits 4..0 feed the selectable outputs |
| nvBusy | input | 1 | Memory program cycle in progress |
| busAck | input | 1 | One-cycle acknowledge strobe of a control register write |
| ctrlWrData | input | 2 | Control write data: bit 1 is register ownership, bit 0 is the source choice |
| muxOut | output | 5 | Selectable outputs |
| latchOut | output | 1 | Held output |
| ctrlRdByte | output | 8 | Control register readback byte |
| wordRdByte | output | 8 | Stored word readback byte |

## Verification
The hardest case to reach is a handover write whose capture can be seen. The held value must differ from the live stored bit 5 at the moment of the acknowledge, and the inputs must then be selected so the captured value is not hidden by transparency. The stimulus gets there in three steps. It first freezes a 0 by raising the select pin, then flips stored bit 5, and then issues the handover write choosing the external inputs. A second hard case is a reprogram that overlaps a change of the live word. This is reached by raising the busy flag and altering the stored word in the same cycle, then toggling the force input and the source during the busy window. A long pseudo-random phase with sparse acknowledge strobes covers the remaining mixes.

// File: rtl/mlo_pkg.sv
package mlo_pkg;
  typedef struct packed {
    logic useStored;  // stored word is the source this cycle
    logic holdLoad;   // hold stage loads stored bit 5 at the next edge
    logic forceZero;  // clamp outputs to zero
  } mloStrobe_t;
endpackage

// File: rtl/mlo_ctrl.sv
module mlo_ctrl
  import mlo_pkg::*;
#(
  parameter int RD_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            selPin,
  input  logic            forceLowN,
  input  logic            busAck,
  input  logic [1:0]      ctrlWrData,
  output mloStrobe_t      stb,
  output logic [RD_W-1:0] ctrlRdByte
);
  logic [1:0] ctrlReg;
  logic       regOwns;
  logic       handover;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= 2'b00;
    else if (busAck) ctrlReg <= ctrlWrData;
  end

  assign regOwns       = ctrlReg[1];
  assign handover      = busAck && ctrlWrData[1] && !regOwns;
  assign stb.useStored = regOwns ? ctrlReg[0] : !selPin;
  assign stb.forceZero = stb.useStored && !forceLowN;
  assign stb.holdLoad  = (!regOwns && !selPin) || handover;
  assign ctrlRdByte    = {{(RD_W-2){1'b0}}, ctrlReg};

  AST_REG_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[1] && $past(ctrlReg) == ctrlReg) |-> $stable(stb.useStored)); // R6
  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busAck) && $past(rstN)) |->
      (ctrlRdByte[1:0] == $past(ctrlWrData) && ctrlRdByte[RD_W-1:2] == '0)); // R11
endmodule

// File: rtl/mlo_data.sv
module mlo_data
  import mlo_pkg::*;
#(
  parameter int NUM_MUX = 5,
  parameter int RD_W    = 8,
  localparam int WORD_W = NUM_MUX + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mloStrobe_t        stb,
  input  logic              nvBusy,
  input  logic [WORD_W-1:0] storedWord,
  input  logic [NUM_MUX-1:0] extIn,
  output logic [NUM_MUX-1:0] muxOut,
  output logic              latchOut,
  output logic [RD_W-1:0]   wordRdByte
);
  logic [WORD_W-1:0] shadow;
  logic [WORD_W-1:0] effWord;
  logic              heldBit;

  // shadow tracks the live word while no program cycle runs
  always_ff @(posedge clk) begin
    if (!rstN) shadow <= '0;
    else if (!nvBusy) shadow <= storedWord;
  end

  assign effWord = nvBusy ? shadow : storedWord;

  always_ff @(posedge clk) begin
    if (!rstN) heldBit <= 1'b0;
    else if (stb.holdLoad) heldBit <= effWord[WORD_W-1];
  end

  for (genvar g = 0; g < NUM_MUX; g++) begin : g_sel
    assign muxOut[g] = stb.useStored ? (effWord[g] && !stb.forceZero) : extIn[g];
  end

  assign latchOut   = stb.useStored ? (effWord[WORD_W-1] && !stb.forceZero) : heldBit;
  assign wordRdByte = {{(RD_W-WORD_W){1'b0}}, storedWord};

  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceZero |-> (muxOut == '0 && !latchOut)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (nvBusy && $past(nvBusy) && stb.useStored && $past(stb.useStored)
     && !stb.forceZero && !$past(stb.forceZero))
      |-> ($stable(muxOut) && $stable(latchOut))); // R10
  AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.useStored && !$past(stb.useStored) && !$past(stb.holdLoad))
      |-> $stable(latchOut)); // R5
endmodule

// File: rtl/mux_latch_out.sv
module mux_latch_out
  import mlo_pkg::*;
#(
  parameter int NUM_MUX = 5,
  parameter int RD_W    = 8,
  localparam int WORD_W = NUM_MUX + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selPin,
  input  logic               forceLowN,
  input  logic [NUM_MUX-1:0] extIn,
  input  logic [WORD_W-1:0]  storedWord,
  input  logic               nvBusy,
  input  logic               busAck,
  input  logic [1:0]         ctrlWrData,
  output logic [NUM_MUX-1:0] muxOut,
  output logic               latchOut,
  output logic [RD_W-1:0]    ctrlRdByte,
  output logic [RD_W-1:0]    wordRdByte
);
  mloStrobe_t stb;

  mlo_ctrl #(.RD_W(RD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selPin(selPin), .forceLowN(forceLowN),
    .busAck(busAck), .ctrlWrData(ctrlWrData), .stb(stb), .ctrlRdByte(ctrlRdByte)
  );

  mlo_data #(.NUM_MUX(NUM_MUX), .RD_W(RD_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .nvBusy(nvBusy), .storedWord(storedWord),
    .extIn(extIn), .muxOut(muxOut), .latchOut(latchOut), .wordRdByte(wordRdByte)
  );
endmodule

// File: tb/mux_latch_out_tb.sv
module mux_latch_out_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selPin = 1'b0;
  logic forceLowN = 1'b1;
  logic [4:0] extIn = 5'b00000;
  logic [5:0] storedWord = 6'b101010;
  logic nvBusy = 1'b0;
  logic busAck = 1'b0;
  logic [1:0] ctrlWrData = 2'b00;
  logic [4:0] muxOut;
  logic latchOut;
  logic [7:0] ctrlRdByte, wordRdByte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [1:0] mCtrl = 2'b00;
  logic mHold = 1'b0;
  logic [5:0] mShadow = 6'b0;

  always #10 clk = ~clk;

  mux_latch_out u_dut (
    .clk(clk), .rstN(rstN), .selPin(selPin), .forceLowN(forceLowN), .extIn(extIn),
    .storedWord(storedWord), .nvBusy(nvBusy), .busAck(busAck), .ctrlWrData(ctrlWrData),
    .muxOut(muxOut), .latchOut(latchOut), .ctrlRdByte(ctrlRdByte), .wordRdByte(wordRdByte)
  );

  function automatic bit modelUseStored();
    if (mCtrl[1]) return mCtrl[0];
    return !selPin;
  endfunction

  function automatic logic [5:0] modelWord();
    return nvBusy ? mShadow : storedWord;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl <= 2'b00; mHold <= 1'b0; mShadow <= 6'b0;
    end else begin
      if (!nvBusy) mShadow <= storedWord;
      if ((!mCtrl[1] && !selPin) || (busAck && ctrlWrData[1] && !mCtrl[1]))
        mHold <= modelWord()[5];
      if (busAck) mCtrl <= ctrlWrData;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit us;
      logic [5:0] w;
      logic [4:0] eMux;
      logic eLat;
      string muxTag, latTag;
      us = modelUseStored();
      w = modelWord();
      if (us) begin
        eMux = forceLowN ? w[4:0] : 5'b0;
        eLat = forceLowN ? w[5] : 1'b0;
      end else begin
        eMux = extIn;
        eLat = mHold;
      end
      muxTag = mCtrl[1] ? "R6 source" : (us ? "R2 stored" : "R3 external");
      latTag = us ? "R4 transparent" : (mCtrl[1] ? "R7 captured" : "R5 frozen");
      if (us && nvBusy) begin muxTag = "R10 busy"; latTag = "R10 busy"; end
      else if (us && !forceLowN) begin muxTag = "R8 force"; latTag = "R8 force"; end
      else if (!us && !forceLowN) begin muxTag = "R9 no force"; latTag = "R9 no force"; end
      check(muxTag, {3'b0, muxOut}, {3'b0, eMux});
      check(latTag, {7'b0, latchOut}, {7'b0, eLat});
      check("R11 ctrl readback", ctrlRdByte, {6'b0, mCtrl});
      check("R11 word readback", wordRdByte, {2'b00, storedWord[5], storedWord[4:0]});
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic ctrlWrite(logic [1:0] d);
    busAck = 1'b1; ctrlWrData = d;
    step(1);
    busAck = 1'b0; ctrlWrData = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    step(3);
    rstN = 1'b1;
    #3;
    check("R1 reset ctrl", ctrlRdByte, 8'h00);
    check("R1 reset select", {3'b0, muxOut}, 8'h0A);
    step(1);
    // R2 / R4 patterns
    storedWord = 6'b010101; step(1);
    storedWord = 6'b111111; extIn = 5'b01100; step(1);
    // R5: freeze 1 on rise, then change word
    selPin = 1'b1; step(1);
    storedWord = 6'b000000; step(2);
    #3; check("R5 frozen high", {7'b0, latchOut}, 8'h01);
    extIn = 5'b10011; step(1);
    // R9: force ignored on external source
    forceLowN = 1'b0; step(2);
    selPin = 1'b0; step(1);              // R8
    forceLowN = 1'b1; step(1);
    // R10 busy window in pin mode
    storedWord = 6'b110011; step(1);
    nvBusy = 1'b1; storedWord = 6'b001100; step(2);
    #3; check("R10 old word shown", {3'b0, muxOut}, 8'h13);
    forceLowN = 1'b0; step(1); forceLowN = 1'b1; step(1);
    nvBusy = 1'b0; step(2);
    // R7: freeze 0, flip bit 5, hand over with inputs chosen
    storedWord = 6'b000001; step(1);
    selPin = 1'b1; step(1);
    storedWord = 6'b100001; step(1);
    ctrlWrite(2'b10);
    #3; check("R7 capture at handover", {7'b0, latchOut}, 8'h01);
    storedWord = 6'b000110; step(1);
    // R6: pin ignored
    selPin = 1'b0; step(2);
    selPin = 1'b1; step(1);
    ctrlWrite(2'b11);
    #3; check("R6 stored chosen", {3'b0, muxOut}, 8'h06);
    selPin = 1'b0; step(1); selPin = 1'b1; step(1);
    forceLowN = 1'b0; step(1); forceLowN = 1'b1; step(1);
    nvBusy = 1'b1; storedWord = 6'b111000; step(2);
    nvBusy = 1'b0; step(1);
    ctrlWrite(2'b01);                    // back to pin mode
    step(2);
    selPin = 1'b0; step(2);
    // pseudo-random phase
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      selPin = lfsr[0];
      forceLowN = lfsr[1] | lfsr[2];
      nvBusy = lfsr[3] & lfsr[4];
      extIn = lfsr[9:5];
      storedWord = lfsr[15:10];
      busAck = (lfsr[7:4] == 4'h0);
      ctrlWrData = lfsr[12:11];
      step(1);
    end
    busAck = 1'b0;
    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule